// File: doc/BRIEF.md
# Fault Counter and Lockout Supervisor

This block watches the fault side of a power-management controller and decides when the system must fall into a latched lockout state. Thirty-one fault flags arrive, each with two enable bits of its own. One enable says the fault pulls the processor reset line. The other says it drives the fail-safe output. Only a fault with both enables set counts as a qualified event. A watchdog error-counter overflow that arrives while the fail-safe output is active is also a qualified event. Each qualified event adds one to a 4-bit fault counter. A qualified fault that stays present is counted again at a fixed recheck interval.

The block enters lockout for any of five causes:
- the counter reaches a limit chosen by a 2-bit field;
- the pre-regulator over-voltage flag is raised;
- a thermal shutdown occurs while the lockout-on-thermal bit is set;
- the reset line is held low for a long time;
- the pre-regulator under-voltage flag persists during the start phase.

The last two causes are timed with a shared slow tick. The bench shortens that tick. The lockout flag and a 3-bit cause code are latched on the first cause and cleared only by the power-on reset.

Top module: `fault_lockout_sup`

## Requirements
- R1: Fault source i is a qualified event only when `flt_src[i]`, `flt_rst_en[i]` and `flt_safe_en[i]` are all 1. The combination `wd_ovf` = 1 and `safe_act` = 1 is also a qualified event. `wd_ovf` alone or `safe_act` alone does not change `fault_count`.
- R2: `fault_count` rises by exactly one at the first clock edge that samples a rising qualified event. Several sources rising in the same cycle still add only one.
- R3: While any qualified event stays present, `fault_count` rises by one again every RECHK_TICKS ticks. The recheck interval is measured from the rise. One tick occurs every TICK_DIV clock cycles.
- R4: `fault_count` saturates at 15.
- R5: `lim_sel` selects the limit: 0→2, 1→6, 2→8, 3→12. At the edge after `fault_count` equals the limit, `lock_out` becomes 1 with `lock_cause` = 3.
- R6: `pre_ov` = 1 sets `lock_out` at the next edge with `lock_cause` = 1.
- R7: `therm_sd` = 1 together with `cfg_therm_lock` = 1 sets `lock_out` at the next edge with `lock_cause` = 2. When `cfg_therm_lock` = 0, `therm_sd` has no effect.
- R8: `mcu_rst_line` held at 0 for RSTLOW_TICKS ticks sets `lock_out` with `lock_cause` = 4. Any return of the line to 1 restarts the timing.
- R9: `pre_uv` = 1 while `pre_start` = 1, held for UV_TICKS ticks, sets `lock_out` with `lock_cause` = 5. `pre_uv` with `pre_start` = 0 has no effect. Any drop of the condition restarts the timing.
- R10: Once set, `lock_out` and `lock_cause` hold until `rst_n` is 0. The first cause keeps its code. If several causes are true in the same cycle, the lowest cause code wins.
- R11: After reset, `fault_count` = 0, `lock_out` = 0 and `lock_cause` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| flt_src | input | 31 | Fault source flags |
| flt_rst_en | input | 31 | Per-source reset-reaction enable |
| flt_safe_en | input | 31 | Per-source fail-safe-reaction enable |
| wd_ovf | input | 1 | Watchdog error-counter overflow |
| safe_act | input | 1 | Fail-safe output currently active |
| mcu_rst_line | input | 1 | Reset line level, 0 = held low |
| pre_ov | input | 1 | Pre-regulator over-voltage flag |
| pre_uv | input | 1 | Pre-regulator under-voltage flag |
| pre_start | input | 1 | Pre-regulator start phase |
| therm_sd | input | 1 | Thermal shutdown flag |
| cfg_therm_lock | input | 1 | Lockout on thermal shutdown enable |
| lim_sel | input | 2 | Counter limit select |
| fault_count | output | 4 | Fault counter value |
| lock_out | output | 1 | Latched lockout |
| lock_cause | output | 3 | Cause code of the lockout |

## Verification
A counter step is visible one edge after the input that causes it. A counter-limit lockout follows one edge after that step. Over-voltage and thermal lockouts appear one edge after their input. The bench therefore samples on the falling edge after the required number of rising edges have passed. The slow tick runs freely, so the timed causes can only be placed within a window of one tick period. For those causes the bench checks that the lockout is still clear after (N-1)·TICK_DIV+1 edges and already set after N·TICK_DIV+1 edges. Recheck increments are checked over a hold of three intervals, a length chosen so the count is exact whatever the tick phase.

// File: rtl/fls_pkg.sv
// Package fls_pkg
// Shared types for the fault lockout supervisor: the cause code and the
// decode of the counter limit select. Assumes a 4-bit counter.
package fls_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_OV      = 3'd1,
        CAUSE_THERM   = 3'd2,
        CAUSE_COUNT   = 3'd3,
        CAUSE_RSTLOW  = 3'd4,
        CAUSE_UVSTART = 3'd5
    } cause_t;

    // Map the 2-bit select onto the counter limit.
    function automatic logic [CNT_W-1:0] lim_decode(input logic [1:0] sel);
        case (sel)
            2'd0:    lim_decode = CNT_W'(2);
            2'd1:    lim_decode = CNT_W'(6);
            2'd2:    lim_decode = CNT_W'(8);
            default: lim_decode = CNT_W'(12);
        endcase
    endfunction

endpackage

// File: rtl/fls_tick.sv
// Module fls_tick
// Free-running prescaler. It emits a one-cycle tick every DIV clocks and is
// shared by all slow timers. Assumes DIV >= 1.
module fls_tick #(
    parameter int DIV = 40000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt;

    // Count the clock cycles of one tick period.
    always_ff @(posedge clk) begin
        if (!rst_n)          pcnt <= '0;
        else if (pcnt == LAST) pcnt <= '0;
        else                 pcnt <= pcnt + PW'(1);
    end

    assign tick = (pcnt == LAST);

    assert_tick_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= LAST);

endmodule

// File: rtl/fls_persist.sv
// Module fls_persist
// Persistence timer. It counts ticks while cond is high and clears as soon as
// cond drops. done is high while cond is high and TICKS ticks have been
// counted. Assumes TICKS >= 1.
module fls_persist #(
    parameter int TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic done
);
    localparam int TW = $clog2(TICKS + 1);
    localparam logic [TW-1:0] FULL = TW'(TICKS);

    logic [TW-1:0] tcnt;

    // Accumulate ticks while the condition persists, clear on its drop.
    always_ff @(posedge clk) begin
        if (!rst_n)                    tcnt <= '0;
        else if (!cond)                tcnt <= '0;
        else if (tick && tcnt != FULL) tcnt <= tcnt + TW'(1);
    end

    assign done = cond && (tcnt == FULL);

    assert_tmr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt <= FULL);

    // R9: the count only steps up by one, holds, or restarts at zero.
    assert_tmr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tcnt == '0 || tcnt == $past(tcnt) || tcnt == $past(tcnt) + TW'(1)));

endmodule

// File: rtl/fls_qualify.sv
// Module fls_qualify
// Fault qualification. A source qualifies only when both of its reactions are
// enabled. A watchdog overflow qualifies while the fail-safe output is active.
// bump pulses on any rising qualified event, and again every RECHK_TICKS ticks
// while some qualified event persists. Assumes RECHK_TICKS >= 2.
module fls_qualify #(
    parameter int NSRC        = 31,
    parameter int RECHK_TICKS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] en_rst,
    input  logic [NSRC-1:0] en_safe,
    input  logic            wd_ovf,
    input  logic            safe_act,
    output logic            bump,
    output logic            any_live
);
    localparam int NQ = NSRC + 1;
    localparam int RW = $clog2(RECHK_TICKS + 1);
    localparam logic [RW-1:0] CLAST = RW'(RECHK_TICKS - 1);

    logic [NQ-1:0] live;
    logic [NQ-1:0] live_q;
    logic [NQ-1:0] fresh;
    logic          rise;
    logic          recheck;
    logic [RW-1:0] chk;

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_src
            assign live[gi] = src[gi] & en_rst[gi] & en_safe[gi];
        end
    endgenerate
    assign live[NSRC] = wd_ovf & safe_act;

    // Remember last cycle's qualified set for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live;
    end

    assign fresh    = live & ~live_q;
    assign rise     = |fresh;
    assign any_live = |live;
    assign recheck  = any_live && !rise && tick && (chk == CLAST);

    // Recheck interval counter, restarted by a rise or by no fault.
    always_ff @(posedge clk) begin
        if (!rst_n)                 chk <= '0;
        else if (!any_live || rise) chk <= '0;
        else if (tick)              chk <= (chk == CLAST) ? '0 : chk + RW'(1);
    end

    assign bump = rise | recheck;

    assert_chk_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chk <= CLAST);

    // R2: a rise always leaves the interval counter restarted.
    assert_rise_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> chk == '0);

endmodule

// File: rtl/fault_lockout_sup.sv
// Module fault_lockout_sup
// Top of the fault supervisor. It holds the saturating 4-bit fault counter,
// compares it against the selected limit, runs the two persistence timers and
// latches the lockout with its first cause. Assumes a synchronous power-on
// reset. The latch is cleared only by that reset.
module fault_lockout_sup
    import fls_pkg::*;
#(
    parameter int NSRC         = 31,
    parameter int TICK_DIV     = 40000,
    parameter int RSTLOW_TICKS = 8000,
    parameter int UV_TICKS     = 5,
    parameter int RECHK_TICKS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  flt_src,
    input  logic [NSRC-1:0]  flt_rst_en,
    input  logic [NSRC-1:0]  flt_safe_en,
    input  logic             wd_ovf,
    input  logic             safe_act,
    input  logic             mcu_rst_line,
    input  logic             pre_ov,
    input  logic             pre_uv,
    input  logic             pre_start,
    input  logic             therm_sd,
    input  logic             cfg_therm_lock,
    input  logic [1:0]       lim_sel,
    output logic [CNT_W-1:0] fault_count,
    output logic             lock_out,
    output logic [2:0]       lock_cause
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             tick;
    logic             bump;
    logic             any_live;
    logic             rstlow_done;
    logic             uv_done;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             hit_count;
    logic             hit_therm;
    cause_t           cause_q;
    cause_t           cause_next;
    logic             lock_q;

    fls_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    fls_qualify #(.NSRC(NSRC), .RECHK_TICKS(RECHK_TICKS)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .src      (flt_src),
        .en_rst   (flt_rst_en),
        .en_safe  (flt_safe_en),
        .wd_ovf   (wd_ovf),
        .safe_act (safe_act),
        .bump     (bump),
        .any_live (any_live)
    );

    fls_persist #(.TICKS(RSTLOW_TICKS)) u_rstlow (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cond  (!mcu_rst_line),
        .done  (rstlow_done)
    );

    fls_persist #(.TICKS(UV_TICKS)) u_uvstart (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cond  (pre_uv && pre_start),
        .done  (uv_done)
    );

    // Saturating fault counter stepped by qualified events.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (bump && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
    end

    assign lim       = lim_decode(lim_sel);
    assign hit_count = (cnt == lim);
    assign hit_therm = therm_sd && cfg_therm_lock;

    // Pick the cause by fixed priority, lowest code first.
    always_comb begin
        if (pre_ov)           cause_next = CAUSE_OV;
        else if (hit_therm)   cause_next = CAUSE_THERM;
        else if (hit_count)   cause_next = CAUSE_COUNT;
        else if (rstlow_done) cause_next = CAUSE_RSTLOW;
        else if (uv_done)     cause_next = CAUSE_UVSTART;
        else                  cause_next = CAUSE_NONE;
    end

    // Latch the first cause and hold it until power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (!lock_q && cause_next != CAUSE_NONE) begin
            lock_q  <= 1'b1;
            cause_q <= cause_next;
        end
    end

    assign fault_count = cnt;
    assign lock_out    = lock_q;
    assign lock_cause  = cause_q;

    // R1: the counter only moves after a qualified event was present.
    assert_step_needs_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) || $past(any_live)));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt == CNT_MAX |=> cnt == CNT_MAX);

    assert_limit_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count |=> lock_out);

    assert_ov_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pre_ov |=> lock_out);

    assert_therm_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_therm |=> lock_out);

    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_out |=> (lock_out && $stable(lock_cause)));

    assert_cause_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_out == (lock_cause != 3'd0));

endmodule

// File: tb/sim_fault_lockout_sup.sv
`timescale 1ns/1ps
module sim_fault_lockout_sup;
    localparam int NS = 31;
    localparam int P  = 4;
    localparam int NR = 8;
    localparam int NU = 5;
    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] flt_src = '0, flt_rst_en = '0, flt_safe_en = '0;
    logic          wd_ovf = 0, safe_act = 0, mcu_rst_line = 1, pre_ov = 0;
    logic          pre_uv = 0, pre_start = 0, therm_sd = 0, cfg_therm_lock = 0;
    logic [1:0]    lim_sel = 2'd3;
    logic [3:0]    fault_count;
    logic          lock_out;
    logic [2:0]    lock_cause;

    int total = 0;
    int failed = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    fault_lockout_sup #(.NSRC(NS), .TICK_DIV(P), .RSTLOW_TICKS(NR),
                        .UV_TICKS(NU), .RECHK_TICKS(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .flt_src(flt_src), .flt_rst_en(flt_rst_en),
        .flt_safe_en(flt_safe_en), .wd_ovf(wd_ovf), .safe_act(safe_act),
        .mcu_rst_line(mcu_rst_line), .pre_ov(pre_ov), .pre_uv(pre_uv),
        .pre_start(pre_start), .therm_sd(therm_sd), .cfg_therm_lock(cfg_therm_lock),
        .lim_sel(lim_sel), .fault_count(fault_count), .lock_out(lock_out),
        .lock_cause(lock_cause));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic [1:0] sel);
        rst_n = 0;
        flt_src = '0; flt_rst_en = '0; flt_safe_en = '0;
        wd_ovf = 0; safe_act = 0; mcu_rst_line = 1; pre_ov = 0;
        pre_uv = 0; pre_start = 0; therm_sd = 0; cfg_therm_lock = 0;
        lim_sel = sel;
        step(3);
        rst_n = 1;
        step(1);
    endtask

    task automatic pulse(input logic [NS-1:0] m);
        flt_src = m;
        step(2);
        flt_src = '0;
        step(2);
    endtask

    initial begin
        step(1);
        restart(2'd3);
        chk("R11 count", fault_count, 0);
        chk("R11 lock", lock_out, 0);
        chk("R11 cause", lock_cause, 0);

        // R1: per-source sweep over all four enable combinations
        for (int s = 0; s < NS; s++) begin
            logic [NS-1:0] one;
            one = NS'(1) << s;
            restart(2'd3);
            for (int c = 0; c < 4; c++) begin
                flt_rst_en  = c[0] ? '1 : ~one;
                flt_safe_en = c[1] ? '1 : ~one;
                pulse(one);
                chk($sformatf("R1 src %0d en %0d", s, c), fault_count, (c == 3) ? 1 : 0);
            end
        end

        // R1: watchdog overflow qualification
        restart(2'd3);
        wd_ovf = 1; step(3); wd_ovf = 0; step(2);
        chk("R1 wd alone", fault_count, 0);
        safe_act = 1; step(3); safe_act = 0; step(2);
        chk("R1 safe alone", fault_count, 0);
        safe_act = 1; wd_ovf = 1; step(2); wd_ovf = 0; safe_act = 0; step(2);
        chk("R1 wd with safe", fault_count, 1);

        // R2: simultaneous rises add one; visible one edge after drive
        restart(2'd3);
        flt_rst_en = '1; flt_safe_en = '1;
        flt_src = 31'h4000_0021;
        step(1);
        chk("R2 one edge later", fault_count, 1);
        step(1); flt_src = '0; step(2);
        chk("R2 multi rise", fault_count, 1);

        // R3: persistent fault over three recheck intervals
        restart(2'd3);
        flt_rst_en = '1; flt_safe_en = '1;
        flt_src = NS'(1);
        step(3 * NC * P + 1);
        chk("R3 recheck count", fault_count, 4);
        flt_src = '0; step(2 * NC * P);
        chk("R3 stops on drop", fault_count, 4);

        // R5/R4/R10: limit sweep, then saturation
        for (int l = 0; l < 4; l++) begin
            int lim;
            lim = (l == 0) ? 2 : (l == 1) ? 6 : (l == 2) ? 8 : 12;
            restart(2'(l));
            flt_rst_en = '1; flt_safe_en = '1;
            for (int k = 1; k <= 17; k++) begin
                pulse(NS'(1) << 3);
                if (k < lim)
                    chk($sformatf("R5 sel %0d pulse %0d lock", l, k), lock_out, 0);
                else if (k == lim) begin
                    chk($sformatf("R5 sel %0d lock", l), lock_out, 1);
                    chk($sformatf("R5 sel %0d cause", l), lock_cause, 3);
                end
            end
            chk($sformatf("R4 sel %0d saturate", l), fault_count, 15);
            pre_ov = 1; step(2); pre_ov = 0;
            chk($sformatf("R10 sel %0d cause kept", l), lock_cause, 3);
        end

        // R6: over-voltage next edge
        restart(2'd3);
        pre_ov = 1; step(1);
        chk("R6 lock", lock_out, 1);
        chk("R6 cause", lock_cause, 1);
        pre_ov = 0; step(5);
        chk("R10 hold after drop", lock_out, 1);
        restart(2'd3);
        chk("R10 cleared by reset", lock_out, 0);

        // R7: thermal with and without configuration
        therm_sd = 1; step(6);
        chk("R7 no cfg", lock_out, 0);
        cfg_therm_lock = 1; step(1);
        chk("R7 lock", lock_out, 1);
        chk("R7 cause", lock_cause, 2);
        pre_ov = 1; step(2);
        chk("R10 first cause", lock_cause, 2);

        // R10: same-cycle tie
        restart(2'd3);
        pre_ov = 1; therm_sd = 1; cfg_therm_lock = 1; step(1);
        chk("R10 tie cause", lock_cause, 1);

        // R8: reset line held low
        restart(2'd3);
        mcu_rst_line = 0; step((NR - 1) * P);
        mcu_rst_line = 1; step(2);
        mcu_rst_line = 0; step((NR - 1) * P);
        mcu_rst_line = 1; step(2);
        chk("R8 restart on release", lock_out, 0);
        mcu_rst_line = 0; step((NR - 1) * P + 1);
        chk("R8 not early", lock_out, 0);
        step(P);
        chk("R8 lock", lock_out, 1);
        chk("R8 cause", lock_cause, 4);

        // R9: under-voltage during start phase
        restart(2'd3);
        pre_uv = 1; step(NU * P + 4);
        chk("R9 outside start", lock_out, 0);
        pre_start = 1; pre_uv = 0; step(2);
        pre_uv = 1; step((NU - 1) * P);
        pre_uv = 0; step(2);
        pre_uv = 1; step((NU - 1) * P);
        pre_uv = 0; step(2);
        chk("R9 restart on drop", lock_out, 0);
        pre_uv = 1; step((NU - 1) * P + 1);
        chk("R9 not early", lock_out, 0);
        step(P);
        chk("R9 lock", lock_out, 1);
        chk("R9 cause", lock_cause, 5);

        finished = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            failed++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule